// File: doc/BRIEF.md
# Output Pin Latch Bank with Write-One Set, Clear and Toggle

This block holds the output value and the direction of a bank of general-purpose pins. A plain write port reaches five locations: a data location that loads the whole latch, three action locations (set, clear, toggle) where each written 1 acts on one latch bit and each written 0 does nothing, and a direction location that decides which pins are driven. Because the action locations touch only the bits written as 1, software can change single pins without reading the latch first.

The latch follows every write whatever the direction of the pin. A pin that is still an input keeps collecting set, clear and toggle changes in its latch bit, and the stored level appears as soon as its direction bit is set. The pin value output is always the latch. The output-enable vector is always the direction register, so the pad logic tristates the pins whose enable is low. The write port takes a select vector with one bit per location. More than one location may be written in the same cycle, with a fixed per-bit priority.

Top module: `gpo_latch_bank`

## Requirements
- R1: After reset the latch and the direction register are all zeros, so `pin_out` and `pin_oe` are zero and every pin is an input.
- R2: A write with select bit 0 (data) loads `wr_data` into the latch. Reading address 0 returns the latch.
- R3: A write with select bit 1 (set) forces to 1 each latch bit whose `wr_data` bit is 1 and leaves every other bit unchanged.
- R4: A write with select bit 2 (clear) forces to 0 each latch bit whose `wr_data` bit is 1 and leaves every other bit unchanged.
- R5: A write with select bit 3 (toggle) inverts each latch bit whose `wr_data` bit is 1 and leaves every other bit unchanged.
- R6: Reading address 1, 2 or 3 (set, clear, toggle) always returns zero, whatever was written there.
- R7: A write with select bit 4 (direction) loads `wr_data` into the direction register. `pin_oe` equals that register, and reading address 4 returns it.
- R8: `pin_out` always equals the latch. The latch changes from writes while the pin is an input. When the pin turns to output, the level held in the latch is driven with no further change. A cycle with no select bit leaves both outputs unchanged.
- R9: When several select bits act on the same latch bit in one cycle, the priority is clear, then set, then toggle (of the old value), then data load.
- R10: Reading addresses 5 to 7 returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_sel | input | 5 | Per-location write strobes: bit0 data, bit1 set, bit2 clear, bit3 toggle, bit4 direction |
| wr_data | input | WIDTH | Write data shared by all selected locations |
| rd_addr | input | 3 | Read location: 0 data, 1 set, 2 clear, 3 toggle, 4 direction |
| rd_data | output | WIDTH | Combinational read-back value |
| pin_out | output | WIDTH | Value for each pin, equal to the latch |
| pin_oe | output | WIDTH | Per-pin output enable, equal to the direction register |

## Verification
The properties assume that `wr_sel` and `wr_data` are stable and known at each rising edge once reset has been released, and that reset is released synchronously with the clock. The toggle and idle properties apply only when that write is the only activity in the cycle, so they rely on the stimulus providing cycles where exactly one strobe, or none, is active. The stimulus changes every input half a clock period away from the rising edge. It interleaves single-strobe writes, idle read cycles and deliberate multi-strobe collisions. It then runs a pseudo-random phase in which any combination of the five strobes may occur.

// File: rtl/gpo_pkg.sv
package gpo_pkg;
   localparam int unsigned NUM_LOC = 5;
   localparam int unsigned ADDR_W  = 3;

   localparam int unsigned SEL_DATA = 0;
   localparam int unsigned SEL_SET  = 1;
   localparam int unsigned SEL_CLR  = 2;
   localparam int unsigned SEL_TGL  = 3;
   localparam int unsigned SEL_DIR  = 4;

   localparam logic [ADDR_W-1:0] RA_DATA = 3'd0;
   localparam logic [ADDR_W-1:0] RA_SET  = 3'd1;
   localparam logic [ADDR_W-1:0] RA_CLR  = 3'd2;
   localparam logic [ADDR_W-1:0] RA_TGL  = 3'd3;
   localparam logic [ADDR_W-1:0] RA_DIR  = 3'd4;

   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_LOAD = 2'd1,
      ACT_INV  = 2'd2,
      ACT_FORCE = 2'd3
   } bit_act_e;
endpackage

// File: rtl/gpo_latch_next.sv
module gpo_latch_next
   import gpo_pkg::*;
#(
   parameter int unsigned WIDTH = 16
) (
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] wdata,
   input  logic             do_load,
   input  logic             do_set,
   input  logic             do_clr,
   input  logic             do_tgl,
   output logic [WIDTH-1:0] nxt,
   output logic             any_act
);
   assign any_act = do_load | do_set | do_clr | do_tgl;

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      bit_act_e act;
      logic     force_val;

      always_comb begin
         act       = ACT_HOLD;
         force_val = 1'b0;
         if (wdata[b] && do_clr) begin
            act       = ACT_FORCE;
            force_val = 1'b0;
         end else if (wdata[b] && do_set) begin
            act       = ACT_FORCE;
            force_val = 1'b1;
         end else if (wdata[b] && do_tgl) begin
            act = ACT_INV;
         end else if (do_load) begin
            act = ACT_LOAD;
         end
      end

      always_comb begin
         unique case (act)
            ACT_FORCE: nxt[b] = force_val;
            ACT_INV:   nxt[b] = ~cur[b];
            ACT_LOAD:  nxt[b] = wdata[b];
            default:   nxt[b] = cur[b];
         endcase
      end
   end
endmodule

// File: rtl/gpo_vec_reg.sv
module gpo_vec_reg #(
   parameter int unsigned WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
   end
endmodule

// File: rtl/gpo_read_mux.sv
module gpo_read_mux
   import gpo_pkg::*;
#(
   parameter int unsigned WIDTH = 16
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [WIDTH-1:0]  latch_q,
   input  logic [WIDTH-1:0]  dir_q,
   output logic [WIDTH-1:0]  data
);
   always_comb begin
      case (addr)
         RA_DATA: data = latch_q;
         RA_DIR:  data = dir_q;
         RA_SET, RA_CLR, RA_TGL: data = '0;
         default: data = '0;
      endcase
   end
endmodule

// File: rtl/gpo_latch_bank.sv
module gpo_latch_bank
   import gpo_pkg::*;
#(
   parameter int unsigned WIDTH = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_LOC-1:0] wr_sel,
   input  logic [WIDTH-1:0]   wr_data,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [WIDTH-1:0]   rd_data,
   output logic [WIDTH-1:0]   pin_out,
   output logic [WIDTH-1:0]   pin_oe
);
   if (WIDTH < 1 || WIDTH > 64) begin : g_bad_width
      $error("gpo_latch_bank: WIDTH must be 1..64");
   end

   logic [WIDTH-1:0] latch_q, latch_d, dir_q;
   logic             latch_en;

   gpo_latch_next #(.WIDTH(WIDTH)) u_next (
      .cur     (latch_q),
      .wdata   (wr_data),
      .do_load (wr_sel[SEL_DATA]),
      .do_set  (wr_sel[SEL_SET]),
      .do_clr  (wr_sel[SEL_CLR]),
      .do_tgl  (wr_sel[SEL_TGL]),
      .nxt     (latch_d),
      .any_act (latch_en)
   );

   gpo_vec_reg #(.WIDTH(WIDTH)) u_latch (
      .clk (clk), .rst_n (rst_n), .en (latch_en), .d (latch_d), .q (latch_q)
   );

   gpo_vec_reg #(.WIDTH(WIDTH)) u_dir (
      .clk (clk), .rst_n (rst_n), .en (wr_sel[SEL_DIR]), .d (wr_data), .q (dir_q)
   );

   gpo_read_mux #(.WIDTH(WIDTH)) u_rd (
      .addr (rd_addr), .latch_q (latch_q), .dir_q (dir_q), .data (rd_data)
   );

   assign pin_out = latch_q;
   assign pin_oe  = dir_q;
endmodule

// File: rtl/gpo_latch_bank_chk.sv
module gpo_latch_bank_chk
   import gpo_pkg::*;
#(
   parameter int unsigned WIDTH = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_LOC-1:0] wr_sel,
   input logic [WIDTH-1:0]   wr_data,
   input logic [ADDR_W-1:0]  rd_addr,
   input logic [WIDTH-1:0]   rd_data,
   input logic [WIDTH-1:0]   pin_out,
   input logic [WIDTH-1:0]   pin_oe
);
   localparam logic [NUM_LOC-1:0] ONLY_TGL = NUM_LOC'(1) << SEL_TGL;

   p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pin_out == '0 && pin_oe == '0));

   p_data_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == RA_DATA) |-> (rd_data == pin_out));

   p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel[SEL_SET] && !wr_sel[SEL_CLR]) |=> ((pin_out & $past(wr_data)) == $past(wr_data)));

   p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel[SEL_CLR] |=> ((pin_out & $past(wr_data)) == '0));

   p_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel == ONLY_TGL) |=> (pin_out == ($past(pin_out) ^ $past(wr_data))));

   p_action_rd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == RA_SET || rd_addr == RA_CLR || rd_addr == RA_TGL) |-> (rd_data == '0));

   p_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel[SEL_DIR] |=> (pin_oe == $past(wr_data)));

   p_idle_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel == '0) |=> ($stable(pin_out) && $stable(pin_oe)));

   p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr > RA_DIR) |-> (rd_data == '0));
endmodule

bind gpo_latch_bank gpo_latch_bank_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/test_gpo_latch_bank.sv
module test_gpo_latch_bank;
   import gpo_pkg::*;
   localparam int W = 16;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [NUM_LOC-1:0] wr_sel = '0;
   logic [W-1:0]       wr_data = '0;
   logic [ADDR_W-1:0]  rd_addr = '0;
   logic [W-1:0]       rd_data, pin_out, pin_oe;

   gpo_latch_bank #(.WIDTH(W)) i_gpo_latch_bank (.*);

   always #10 clk = ~clk;

   typedef struct packed { logic [W-1:0] out; logic [W-1:0] oe; } exp_t;
   exp_t  sb_q[$];
   string sb_tag[$];
   int    n_chk = 0, n_fail = 0;
   logic [W-1:0] m_lat = '0, m_dir = '0;
   bit    done = 0;

   task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // per-bit priority: clear > set > toggle(old) > data load
   task automatic model(logic [NUM_LOC-1:0] s, logic [W-1:0] d);
      logic [W-1:0] base, t, st, c, nl;
      base = s[SEL_DATA] ? d : m_lat;
      t    = s[SEL_TGL] ? d : '0;
      st   = s[SEL_SET] ? d : '0;
      c    = s[SEL_CLR] ? d : '0;
      nl   = (~m_lat & t) | (base & ~t);
      nl   = (nl | st) & ~c;
      m_lat = nl;
      if (s[SEL_DIR]) m_dir = d;
   endtask

   task automatic drive(logic [NUM_LOC-1:0] s, logic [W-1:0] d, string tag);
      @(negedge clk);
      wr_sel  = s;
      wr_data = d;
      model(s, d);
      sb_q.push_back('{out: m_lat, oe: m_dir});
      sb_tag.push_back(tag);
   endtask

   task automatic rd(logic [ADDR_W-1:0] a, logic [W-1:0] exp, string tag);
      drive('0, '0, tag);
      rd_addr = a;
      #2;
      check(tag, rd_data, exp);
   endtask

   // monitor: pops one expected item per edge, compares a quarter period later
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (sb_q.size() > 0) begin
            exp_t  e;
            string t;
            e = sb_q.pop_front();
            t = sb_tag.pop_front();
            check({t, " pin_out"}, pin_out, e.out);
            check({t, " pin_oe"}, pin_oe, e.oe);
         end
      end
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] lf;
      repeat (3) @(negedge clk);
      check("R1 reset pin_out", pin_out, '0);
      check("R1 reset pin_oe", pin_oe, '0);
      rd_addr = RA_DIR; #1;
      check("R1 reset dir read", rd_data, '0);
      @(negedge clk);
      rst_n = 1'b1;

      rd(RA_DATA, 16'h0000, "R1 latch read after reset");
      drive(5'b00001, 16'hA5C3, "R2 data load");
      rd(RA_DATA, 16'hA5C3, "R2 data read");
      drive(5'b00010, 16'h0F00, "R3 set");
      rd(RA_DATA, 16'hAFC3, "R3 set read");
      drive(5'b00100, 16'h0003, "R4 clear");
      rd(RA_DATA, 16'hAFC0, "R4 clear read");
      drive(5'b01000, 16'hFFFF, "R5 toggle while input");
      rd(RA_DATA, 16'h503F, "R8 latch moves while input");
      check("R8 pins still off", pin_oe, '0);
      drive(5'b00010, 16'h0000, "R3 zero set no effect");
      drive(5'b00100, 16'h0000, "R4 zero clear no effect");
      drive(5'b01000, 16'h0000, "R5 zero toggle no effect");
      rd(RA_DATA, 16'h503F, "R8 zero action writes");
      drive(5'b10000, 16'h00FF, "R7 dir to output");
      rd(RA_DIR, 16'h00FF, "R7 dir read");
      check("R8 held value driven", pin_out, 16'h503F);
      drive(5'b00010, 16'hFFFF, "R6 set write");
      rd(RA_SET, '0, "R6 set reads zero");
      drive(5'b00100, 16'h1234, "R6 clear write");
      rd(RA_CLR, '0, "R6 clear reads zero");
      drive(5'b01000, 16'h5555, "R6 toggle write");
      rd(RA_TGL, '0, "R6 toggle reads zero");
      for (int a = 5; a < 8; a++) rd(ADDR_W'(a), '0, "R10 unmapped read");

      drive(5'b00001, 16'h00F0, "R9 setup");
      drive(5'b00110, 16'h0FF0, "R9 clear beats set");
      drive(5'b01010, 16'hFF00, "R9 set beats toggle");
      drive(5'b01001, 16'h0F0F, "R9 toggle beats load");
      drive(5'b01111, 16'hC3C3, "R9 all four");
      rd(RA_DATA, m_lat, "R9 read after collisions");

      lf = 16'hACE1;
      for (int i = 0; i < 300; i++) begin
         logic [15:0] d;
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         d  = lf ^ 16'h9E37;
         if (lf[7:5] == 3'd0) rd(lf[2:0], (lf[2:0] == RA_DATA) ? m_lat :
                                           (lf[2:0] == RA_DIR) ? m_dir : '0, "R2 R7 R10 random read");
         else drive(lf[4:0], d, "R9 random mix");
      end
      drive('0, '0, "R8 final idle");
      repeat (3) @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule